// File: doc/BRIEF.md
# Register File with Return-Address Stack

This block is the general purpose register file of a small control-path processor. It has 32 architectural registers of 32 bits, two combinational read ports and one synchronous write port, all with 5-bit addresses. Address 0 is a constant zero. Address 1 holds no storage of its own. It gives access to a hardware last-in, first-out stack of return addresses: an enabled read of address 1 removes the top entry and returns it, and a write to address 1 places a new entry on top. Addresses 2 to 31 are plain storage cells.

The decode stage drives each read port with an address and a read-enable. The enable marks a real architectural read and so decides whether a pop happens. The block reports the stack occupancy as an empty flag, a full flag and a depth count. It raises a one-cycle error pulse when software misuses the stack, either by reading from an empty stack or by writing to a full one. The stack depth is a parameter with a default of 8.

Top module: `gpr_ras_regfile`

## Requirements
- R1: Registers 2 to 31 return the last value written to them. A write becomes visible on the read ports from the cycle after the write-enable edge. After reset every one of them reads 0.
- R2: Address 0 always reads 0 on both ports, and a write to address 0 has no visible effect.
- R3: A write to address 1 pushes the write data: the depth rises by one and the value shows on a read of address 1 from the next cycle.
- R4: While address 1 is selected, a read port shows the top entry. Only when that port's read-enable is high is the entry removed, which lowers the depth by one on the next edge.
- R5: An enabled read of address 1 while the stack is empty returns 0, raises the error output in that same cycle and leaves the depth at 0.
- R6: A write to address 1 while the stack is full and no pop happens in that cycle raises the error output in that cycle. The data is dropped: depth and top entry stay unchanged.
- R7: When both read ports perform an enabled read of address 1 in one cycle, exactly one entry is popped and both ports return the same value.
- R8: A cycle with both an enabled read of address 1 and a write to address 1 pops first and then pushes. On a non-empty stack the depth stays the same and the top entry is replaced by the write data. On an empty stack the pop raises the error and the push still lands, giving depth 1.
- R9: The empty flag is high exactly when the depth is 0, and the full flag is high exactly when the depth equals the stack parameter. Reset leaves the stack empty.
- R10: The error output is low in every cycle that has neither of the misuse cases of R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_a_i | input | 1 | Port A performs an architectural read (pops when address is 1) |
| rd_addr_a_i | input | 5 | Port A register address |
| rd_data_a_o | output | 32 | Port A read data, combinational |
| rd_en_b_i | input | 1 | Port B performs an architectural read (pops when address is 1) |
| rd_addr_b_i | input | 5 | Port B register address |
| rd_data_b_o | output | 32 | Port B read data, combinational |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 32 | Write data |
| stk_empty_o | output | 1 | Return-address stack holds no entries |
| stk_full_o | output | 1 | Return-address stack holds the maximum number of entries |
| stk_depth_o | output | 4 | Current number of stack entries |
| stk_err_o | output | 1 | One-cycle pulse on stack underflow or overflow |

## Verification
The assertions assume that the inputs are stable and known around each rising edge. They also assume that the read-enables are the only source of pops, so a read-enable asserted on address 1 always counts as an architectural access. The stimulus changes every input only at the falling edge and holds it for a full cycle. It keeps the addresses and enables at defined values from reset onward. Random traffic is skewed toward addresses 0 to 3 so that pushes, pops, dual pops, swaps, underflow and overflow all occur, alongside ordinary register traffic.

// File: rtl/gpr_ras_pkg.sv
package gpr_ras_pkg;

  localparam int unsigned GPR_W    = 32;
  localparam int unsigned GPR_N    = 32;
  localparam int unsigned GPR_AW   = $clog2(GPR_N);
  localparam int unsigned ZERO_IDX = 0;
  localparam int unsigned LINK_IDX = 1;

  // Depth after one cycle: pop is applied before push.
  function automatic int unsigned ras_depth_after(int unsigned depth,
                                                  logic pop_ok,
                                                  logic push_ok);
    int unsigned d;
    d = depth;
    if (pop_ok)  d = d - 1;
    if (push_ok) d = d + 1;
    return d;
  endfunction

  // A push fits when the depth left after the pop is below the limit.
  function automatic logic ras_push_fits(int unsigned depth,
                                         logic pop_ok,
                                         int unsigned limit);
    int unsigned d;
    d = pop_ok ? depth - 1 : depth;
    return d < limit;
  endfunction

endpackage

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_ras_pkg::*;
#(
  parameter int unsigned W    = GPR_W,
  parameter int unsigned NREG = GPR_N,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           wr_addr_i,
  input  logic [W-1:0]            wr_data_i,
  output logic [NREG-1:0][W-1:0]  regs_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == ZERO_IDX || g == LINK_IDX) begin : g_none
      assign regs_o[g] = '0;
    end else begin : g_cell
      logic hit;
      assign hit = wr_en_i && (wr_addr_i == AW'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  regs_o[g] <= '0;
        else if (hit) regs_o[g] <= wr_data_i;
      end
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i > AW'(LINK_IDX)) |=> regs_o[$past(wr_addr_i)] == $past(wr_data_i)); // R1

endmodule

// File: rtl/gpr_ras_lifo.sv
module gpr_ras_lifo
  import gpr_ras_pkg::*;
#(
  parameter int unsigned W     = GPR_W,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned DW   = $clog2(DEPTH + 1),
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_req_i,
  input  logic          push_req_i,
  input  logic [W-1:0]  push_data_i,
  output logic [W-1:0]  top_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [DW-1:0] depth_o,
  output logic          underflow_o,
  output logic          overflow_o
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [DW-1:0] depth_q;
  logic          pop_ok, push_ok;
  logic [IW-1:0] top_idx, wr_idx;

  assign empty_o = (depth_q == '0);
  assign full_o  = (depth_q == DW'(DEPTH));
  assign depth_o = depth_q;

  assign pop_ok  = pop_req_i && !empty_o;
  assign push_ok = push_req_i && ras_push_fits(int'(depth_q), pop_ok, DEPTH);

  assign underflow_o = pop_req_i && empty_o;
  assign overflow_o  = push_req_i && !push_ok;

  assign top_idx = IW'(depth_q - DW'(1));
  assign wr_idx  = pop_ok ? top_idx : IW'(depth_q);
  assign top_o   = empty_o ? '0 : mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      depth_q <= DW'(ras_depth_after(int'(depth_q), pop_ok, push_ok));
      if (push_ok) mem_q[wr_idx] <= push_data_i;
    end
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DW'(DEPTH)); // R9
  AST_PUSH_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok && !pop_ok) |=> (depth_o == $past(depth_o) + DW'(1)) && (top_o == $past(push_data_i))); // R3
  AST_POP_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_ok && !push_ok) |=> depth_o == $past(depth_o) - DW'(1)); // R4
  AST_SWAP_KEEPS_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_ok && push_ok) |=> $stable(depth_o) && (top_o == $past(push_data_i))); // R8
  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> $stable(depth_o) && $stable(top_o)); // R6
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({empty_o, full_o})); // R9

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_ras_pkg::*;
#(
  parameter int unsigned W    = GPR_W,
  parameter int unsigned NREG = GPR_N,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic [AW-1:0]          addr_i,
  input  logic [NREG-1:0][W-1:0] regs_i,
  input  logic [W-1:0]           stk_top_i,
  output logic [W-1:0]           data_o,
  output logic                   sel_link_o
);

  assign sel_link_o = (addr_i == AW'(LINK_IDX));

  always_comb begin
    if (addr_i == AW'(ZERO_IDX)) data_o = '0;
    else if (sel_link_o)         data_o = stk_top_i;
    else                         data_o = regs_i[addr_i];
  end

endmodule

// File: rtl/gpr_ras_regfile.sv
module gpr_ras_regfile
  import gpr_ras_pkg::*;
#(
  parameter int unsigned W         = GPR_W,
  parameter int unsigned NREG      = GPR_N,
  parameter int unsigned RAS_DEPTH = 8,
  localparam int unsigned AW       = $clog2(NREG),
  localparam int unsigned DW       = $clog2(RAS_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_a_i,
  input  logic [AW-1:0] rd_addr_a_i,
  output logic [W-1:0]  rd_data_a_o,
  input  logic          rd_en_b_i,
  input  logic [AW-1:0] rd_addr_b_i,
  output logic [W-1:0]  rd_data_b_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  output logic          stk_empty_o,
  output logic          stk_full_o,
  output logic [DW-1:0] stk_depth_o,
  output logic          stk_err_o
);

  logic [NREG-1:0][W-1:0] regs;
  logic [W-1:0]           stk_top;
  logic                   link_a, link_b;
  logic                   evt_pop_req, evt_push_req;
  logic                   evt_underflow, evt_overflow;

  gpr_bank #(.W(W), .NREG(NREG)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .regs_o    (regs)
  );

  gpr_read_port #(.W(W), .NREG(NREG)) u_port_a (
    .addr_i     (rd_addr_a_i),
    .regs_i     (regs),
    .stk_top_i  (stk_top),
    .data_o     (rd_data_a_o),
    .sel_link_o (link_a)
  );

  gpr_read_port #(.W(W), .NREG(NREG)) u_port_b (
    .addr_i     (rd_addr_b_i),
    .regs_i     (regs),
    .stk_top_i  (stk_top),
    .data_o     (rd_data_b_o),
    .sel_link_o (link_b)
  );

  // Both ports share one pop request, so a dual read removes a single entry.
  assign evt_pop_req  = (rd_en_a_i && link_a) || (rd_en_b_i && link_b);
  assign evt_push_req = wr_en_i && (wr_addr_i == AW'(LINK_IDX));

  gpr_ras_lifo #(.W(W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_req_i   (evt_pop_req),
    .push_req_i  (evt_push_req),
    .push_data_i (wr_data_i),
    .top_o       (stk_top),
    .empty_o     (stk_empty_o),
    .full_o      (stk_full_o),
    .depth_o     (stk_depth_o),
    .underflow_o (evt_underflow),
    .overflow_o  (evt_overflow)
  );

  assign stk_err_o = evt_underflow || evt_overflow;

  AST_ZERO_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_a_i == '0) |-> (rd_data_a_o == '0)); // R2
  AST_UNDERFLOW_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_pop_req && stk_empty_o) |-> stk_err_o && (stk_depth_o == '0)); // R5
  AST_DUAL_POP_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_a_i && link_a && rd_en_b_i && link_b) |-> (rd_data_a_o == rd_data_b_o)); // R7
  AST_DUAL_POP_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_a_i && link_a && rd_en_b_i && link_b && !stk_empty_o && !evt_push_req)
      |=> stk_depth_o == $past(stk_depth_o) - DW'(1)); // R7
  AST_ERR_ONLY_ON_MISUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_pop_req && !evt_push_req) |-> !stk_err_o); // R10

endmodule

// File: tb/gpr_ras_regfile_tb.sv
module gpr_ras_regfile_tb;

  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en_a = 1'b0, rd_en_b = 1'b0, wr_en = 1'b0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data_a, rd_data_b;
  logic        stk_empty, stk_full, stk_err;
  logic [3:0]  stk_depth;

  int tests = 0;
  int fails = 0;

  // reference model
  int unsigned ref_regs [32];
  int unsigned ref_stk [$];

  always #2 clk = ~clk;

  gpr_ras_regfile u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rd_en_a_i   (rd_en_a),
    .rd_addr_a_i (rd_addr_a),
    .rd_data_a_o (rd_data_a),
    .rd_en_b_i   (rd_en_b),
    .rd_addr_b_i (rd_addr_b),
    .rd_data_b_o (rd_data_b),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .stk_empty_o (stk_empty),
    .stk_full_o  (stk_full),
    .stk_depth_o (stk_depth),
    .stk_err_o   (stk_err)
  );

  task automatic check(string req, string what, longint got, longint exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  function automatic int unsigned model_read(logic [4:0] a);
    if (a == 0) return 0;
    if (a == 1) return (ref_stk.size() == 0) ? 0 : ref_stk[$];
    return ref_regs[a];
  endfunction

  // One clock: drive at falling edge, compare just before the rising edge,
  // then advance the model to the post-edge state.
  task automatic step(bit ea, logic [4:0] aa, bit eb, logic [4:0] ab,
                      bit we, logic [4:0] wa, logic [31:0] wd, string req);
    bit pop_req, push_req, pop_ok, exp_err;
    int sz;
    @(negedge clk);
    rd_en_a = ea; rd_addr_a = aa; rd_en_b = eb; rd_addr_b = ab;
    wr_en = we; wr_addr = wa; wr_data = wd;
    #1;
    sz       = ref_stk.size();
    pop_req  = (ea && aa == 1) || (eb && ab == 1);
    push_req = we && wa == 1;
    pop_ok   = pop_req && sz > 0;
    exp_err  = (pop_req && sz == 0) || (push_req && (sz - int'(pop_ok)) >= D);
    check(req, "rd_data_a", rd_data_a, model_read(aa));
    check(req, "rd_data_b", rd_data_b, model_read(ab));
    check(req, "stk_err", stk_err, exp_err);
    check("R9", "stk_depth", stk_depth, sz);
    check("R9", "stk_empty", stk_empty, sz == 0);
    check("R9", "stk_full", stk_full, sz == D);
    if (pop_ok) void'(ref_stk.pop_back());
    if (push_req && ref_stk.size() < D) ref_stk.push_back(wd);
    if (we && wa >= 2) ref_regs[wa] = wd;
  endtask

  task automatic idle(logic [4:0] aa, logic [4:0] ab, string req);
    step(0, aa, 0, ab, 0, 0, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    for (int i = 0; i < 32; i++) ref_regs[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state
    idle(5, 31, "R1");
    idle(1, 2, "R9");

    // ordinary registers
    for (int i = 2; i < 32; i++)
      step(0, 0, 0, 0, 1, 5'(i), 32'hA5A5_0000 ^ (i * 32'h0101_0101), "R1");
    for (int i = 2; i < 32; i += 2) idle(5'(i), 5'(i + 1), "R1");
    // write then immediate read sees old value, next cycle new value
    step(1, 9, 0, 0, 1, 9, 32'hDEAD_BEEF, "R1");
    idle(9, 9, "R1");

    // zero register
    step(1, 0, 1, 0, 1, 0, 32'hFFFF_FFFF, "R2");
    idle(0, 0, "R2");

    // push, peek without enable, pop with enable
    step(0, 0, 0, 0, 1, 1, 32'h0000_0100, "R3");
    step(0, 1, 0, 1, 1, 1, 32'h0000_0200, "R3");
    idle(1, 1, "R4");
    idle(1, 3, "R4");
    step(1, 1, 0, 0, 0, 0, 0, "R4");
    idle(1, 0, "R4");

    // dual pop on one remaining + new entry
    step(0, 0, 0, 0, 1, 1, 32'h0000_0300, "R7");
    step(1, 1, 1, 1, 0, 0, 0, "R7");
    idle(1, 0, "R7");
    step(1, 1, 1, 1, 0, 0, 0, "R7");

    // underflow
    step(1, 1, 0, 4, 0, 0, 0, "R5");
    step(0, 4, 1, 1, 0, 0, 0, "R5");
    idle(1, 1, "R5");

    // fill and overflow
    for (int i = 0; i < D; i++) step(0, 1, 0, 0, 1, 1, 32'h1000 + i, "R3");
    step(0, 1, 0, 0, 1, 1, 32'hBAD0_0001, "R6");
    idle(1, 1, "R6");
    // swap while full: no overflow
    step(1, 1, 0, 0, 1, 1, 32'h5A5A_0001, "R8");
    idle(1, 1, "R8");
    // drain
    for (int i = 0; i < D; i++) step(1, 1, 0, 0, 0, 0, 0, "R4");
    // swap on empty stack
    step(1, 1, 1, 1, 1, 1, 32'h5A5A_0002, "R8");
    idle(1, 1, "R8");
    step(0, 0, 1, 1, 1, 1, 32'h5A5A_0003, "R8");
    idle(1, 0, "R8");

    // random traffic
    lcg = 32'h1234_5678;
    for (int n = 0; n < 600; n++) begin
      logic [4:0] aa, ab, wa;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      aa = (lcg[3:2] == 0) ? lcg[20:16] : {3'b000, lcg[17:16]};
      ab = (lcg[5:4] == 0) ? lcg[25:21] : {3'b000, lcg[22:21]};
      wa = (lcg[7:6] == 0) ? lcg[30:26] : {3'b000, lcg[27:26]};
      step(lcg[8], aa, lcg[9] & lcg[10], ab, lcg[11], wa, lcg ^ 32'h0F0F_F0F0, "R10");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule